// File: doc/BRIEF.md
# Debug Output Port

This block sits in the I/O address space of a processor bus and turns plain word writes into debug events. Firmware writes to one of four word slots above a configurable base address. Each slot has its own result. One slot emits a screen character. A second emits a character on an independent text channel. A third emits a full 32-bit integer. The fourth raises a run-complete flag that stays set.

Memory accesses are never decoded: the block reacts only while the I/O-select input marks the transfer as I/O. Every accepted write produces a registered one-cycle strobe together with its payload, one clock after the write is sampled. A consumer outside the block turns these strobes into terminal output, text or file records, or a simulation stop. Reads are accepted silently and return zero.

Top module: `dbg_emit_port`

## Requirements
- R1: While `io_sel` is low, no write produces any strobe and leaves `done` unchanged.
- R2: An I/O write (`io_sel`, `bus_req` and `bus_we` all high) to BASE_ADDR+0 raises `scr_stb` on the following cycle, with `scr_char` equal to bits 7:0 of the written word.
- R3: An I/O write to BASE_ADDR+4 raises `txt_stb` on the following cycle, with `txt_char` equal to bits 7:0 of the written word.
- R4: An I/O write to BASE_ADDR+8 raises `int_stb` on the following cycle, with `int_val` equal to the whole 32-bit written word.
- R5: An I/O write to BASE_ADDR+12 sets `done` on the following cycle whatever the data value, and raises no channel strobe.
- R6: Each strobe is high for exactly one cycle per accepted write, and at most one of the three strobes is high in any cycle.
- R7: Once set, `done` stays high until reset, whatever traffic follows.
- R8: Reads (`bus_we` low), and writes to any address outside the four aligned word slots (other offsets, unaligned byte addresses, other base), have no effect, and `bus_rdata` is always zero.
- R9: A low `rst_n` at a rising clock edge clears all strobes, all channel data and `done`, and it takes priority over a write presented in the same cycle.
- R10: Between accepted writes, each channel data output holds the last value it delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_sel | input | 1 | High when the current access targets I/O space |
| bus_req | input | 1 | Access valid in this cycle |
| bus_we | input | 1 | High for write, low for read |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| scr_stb | output | 1 | Screen character valid, one cycle |
| scr_char | output | 8 | Screen character |
| txt_stb | output | 1 | Text-channel character valid, one cycle |
| txt_char | output | 8 | Text-channel character |
| int_stb | output | 1 | Integer valid, one cycle |
| int_val | output | 32 | Integer value |
| done | output | 1 | Sticky run-complete flag |

## Verification
Two of the block's functions can fall in the same cycle: a synchronous reset, and an I/O write that would set a strobe or the run-complete flag. The bench provokes this by holding `rst_n` low while it presents an integer write, after `done` has already been set by an earlier halt write. It then checks on the next cycle that the integer strobe stayed low, the integer data cleared to zero and `done` dropped. The bench also sets `done` and then keeps sending channel writes. It checks that the character strobes still arrive while the flag stays set.

// File: rtl/dbg_emit_pkg.sv
package dbg_emit_pkg;
   localparam int NUM_SLOTS = 4;
   localparam int SLOT_BITS = $clog2(NUM_SLOTS);
   localparam int WORD_BYTES = 4;
   localparam int BYTE_BITS = $clog2(WORD_BYTES);
   localparam int WIN_LSB = SLOT_BITS + BYTE_BITS;

   typedef enum logic [SLOT_BITS-1:0] {
      SLOT_SCREEN  = 2'd0,
      SLOT_TEXT    = 2'd1,
      SLOT_INTEGER = 2'd2,
      SLOT_HALT    = 2'd3
   } dbg_slot_e;
endpackage

// File: rtl/dbg_emit_decode.sv
module dbg_emit_decode
   import dbg_emit_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
   input  logic              io_sel,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_SLOTS-1:0] slot_hit
);
   logic in_window;
   logic aligned;

   assign in_window = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
   assign aligned   = (addr[BYTE_BITS-1:0] == '0);

   always_comb begin
      slot_hit = '0;
      if (io_sel && req && we && in_window && aligned)
         slot_hit[addr[WIN_LSB-1:BYTE_BITS]] = 1'b1;
   end
endmodule

// File: rtl/dbg_emit_chan.sv
module dbg_emit_chan #(
   parameter int W = 8,
   parameter bit HOLD_DATA = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic         stb,
   output logic [W-1:0] dout
);
   always_ff @(posedge clk) begin
      if (!rst_n) stb <= 1'b0;
      else        stb <= load;
   end

   generate
      if (HOLD_DATA) begin : g_hold
         always_ff @(posedge clk) begin
            if (!rst_n)    dout <= '0;
            else if (load) dout <= din;
         end
      end else begin : g_pulse
         always_ff @(posedge clk) begin
            if (!rst_n) dout <= '0;
            else        dout <= load ? din : '0;
         end
      end
   endgenerate
endmodule

// File: rtl/dbg_emit_halt.sv
module dbg_emit_halt (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   output logic halt
);
   always_ff @(posedge clk) begin
      if (!rst_n)   halt <= 1'b0;
      else if (set) halt <= 1'b1;
   end

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> halt); // R7
endmodule

// File: rtl/dbg_emit_port.sv
module dbg_emit_port
   import dbg_emit_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CHAR_W = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8000_0000,
   parameter bit HOLD_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_sel,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              scr_stb,
   output logic [CHAR_W-1:0] scr_char,
   output logic              txt_stb,
   output logic [CHAR_W-1:0] txt_char,
   output logic              int_stb,
   output logic [DATA_W-1:0] int_val,
   output logic              done
);
   if (CHAR_W > DATA_W) begin : g_bad_char
      $error("CHAR_W must not exceed DATA_W");
   end
   if (ADDR_W <= WIN_LSB) begin : g_bad_addr
      $error("ADDR_W too small for the slot window");
   end
   if (BASE_ADDR[WIN_LSB-1:0] != '0) begin : g_bad_base
      $error("BASE_ADDR must be aligned to the slot window");
   end

   logic [NUM_SLOTS-1:0] slot_hit;

   dbg_emit_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) decode_i (
      .io_sel(io_sel), .req(bus_req), .we(bus_we), .addr(bus_addr),
      .slot_hit(slot_hit)
   );

   dbg_emit_chan #(.W(CHAR_W), .HOLD_DATA(HOLD_DATA)) scr_i (
      .clk(clk), .rst_n(rst_n), .load(slot_hit[SLOT_SCREEN]),
      .din(bus_wdata[CHAR_W-1:0]), .stb(scr_stb), .dout(scr_char)
   );

   dbg_emit_chan #(.W(CHAR_W), .HOLD_DATA(HOLD_DATA)) txt_i (
      .clk(clk), .rst_n(rst_n), .load(slot_hit[SLOT_TEXT]),
      .din(bus_wdata[CHAR_W-1:0]), .stb(txt_stb), .dout(txt_char)
   );

   dbg_emit_chan #(.W(DATA_W), .HOLD_DATA(HOLD_DATA)) int_i (
      .clk(clk), .rst_n(rst_n), .load(slot_hit[SLOT_INTEGER]),
      .din(bus_wdata), .stb(int_stb), .dout(int_val)
   );

   dbg_emit_halt halt_i (
      .clk(clk), .rst_n(rst_n), .set(slot_hit[SLOT_HALT]), .halt(done)
   );

   assign bus_rdata = '0;

   logic halt_write;
   assign halt_write = io_sel && bus_req && bus_we &&
                       (bus_addr == BASE_ADDR + ADDR_W'(12));

   AST_IO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !io_sel |=> !(scr_stb || txt_stb || int_stb)); // R1
   AST_SCR_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      scr_stb |-> scr_char == $past(bus_wdata[CHAR_W-1:0])); // R2
   AST_TXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      txt_stb |-> txt_char == $past(bus_wdata[CHAR_W-1:0])); // R3
   AST_INT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      int_stb |-> int_val == $past(bus_wdata)); // R4
   AST_HALT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      halt_write |=> done && !(scr_stb || txt_stb || int_stb)); // R5
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({scr_stb, txt_stb, int_stb})); // R6
   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> !(scr_stb || txt_stb || int_stb || done)); // R9
endmodule

// File: tb/dbg_emit_port_tb.sv
module dbg_emit_port_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] BASE = 32'h8000_0000;
   localparam int NVEC = 10;
   // vector: io[68] req[67] we[66] addr[65:34] data[33:2] expected channel[1:0]
   // expected channel: 0 none, 1 screen, 2 text, 3 integer
   localparam logic [68:0] VEC [NVEC] = '{
      {1'b1, 1'b1, 1'b1, BASE + 32'd0,  32'h1234_5641, 2'd1},   // R2
      {1'b1, 1'b1, 1'b1, BASE + 32'd4,  32'hFFFF_FF7A, 2'd2},   // R3
      {1'b1, 1'b1, 1'b1, BASE + 32'd8,  32'hDEAD_BEEF, 2'd3},   // R4
      {1'b0, 1'b1, 1'b1, BASE + 32'd0,  32'h0000_0055, 2'd0},   // R1
      {1'b1, 1'b1, 1'b0, BASE + 32'd8,  32'h0BAD_0BAD, 2'd0},   // R8 read
      {1'b1, 1'b1, 1'b1, BASE + 32'd16, 32'h0000_0066, 2'd0},   // R8 other offset
      {1'b1, 1'b1, 1'b1, BASE + 32'd2,  32'h0000_0067, 2'd0},   // R8 unaligned
      {1'b1, 1'b1, 1'b1, 32'h9000_0000, 32'h0000_0068, 2'd0},   // R8 other base
      {1'b1, 1'b1, 1'b1, BASE + 32'd0,  32'h0000_0062, 2'd1},   // R6 back to back
      {1'b1, 1'b1, 1'b1, BASE + 32'd0,  32'h0000_0063, 2'd1}    // R6 back to back
   };

   logic clk = 1'b0;
   logic rst_n;
   logic io_sel, bus_req, bus_we;
   logic [31:0] bus_addr, bus_wdata, bus_rdata;
   logic scr_stb, txt_stb, int_stb, done;
   logic [7:0] scr_char, txt_char;
   logic [31:0] int_val;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   logic [7:0]  m_scr = '0;
   logic [7:0]  m_txt = '0;
   logic [31:0] m_int = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_emit_port dut_i (
      .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .bus_req(bus_req),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .scr_stb(scr_stb), .scr_char(scr_char),
      .txt_stb(txt_stb), .txt_char(txt_char), .int_stb(int_stb),
      .int_val(int_val), .done(done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic io, input logic rq, input logic w,
                        input logic [31:0] a, input logic [31:0] d);
      io_sel = io; bus_req = rq; bus_we = w; bus_addr = a; bus_wdata = d;
   endtask

   task automatic check_outputs(input string tag, input logic [2:0] stbs, input logic dn);
      chk({tag, " strobes"}, {29'd0, scr_stb, txt_stb, int_stb}, {29'd0, stbs});
      chk({tag, " done"}, {31'd0, done}, {31'd0, dn});
      chk({tag, " scr_char R10"}, {24'd0, scr_char}, {24'd0, m_scr});
      chk({tag, " txt_char R10"}, {24'd0, txt_char}, {24'd0, m_txt});
      chk({tag, " int_val R10"}, int_val, m_int);
      chk("R8 rdata zero", bus_rdata, 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      drive(1'b0, 1'b0, 1'b0, 32'd0, 32'd0);
      repeat (2) @(negedge clk);
      check_outputs("R9 reset state", 3'b000, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         logic [1:0] ech;
         logic [2:0] exp_stb;
         drive(VEC[i][68], VEC[i][67], VEC[i][66], VEC[i][65:34], VEC[i][33:2]);
         ech = VEC[i][1:0];
         @(negedge clk);
         exp_stb = 3'b000;
         case (ech)
            2'd1: begin exp_stb = 3'b100; m_scr = VEC[i][9:2]; end
            2'd2: begin exp_stb = 3'b010; m_txt = VEC[i][9:2]; end
            2'd3: begin exp_stb = 3'b001; m_int = VEC[i][33:2]; end
            default: ;
         endcase
         check_outputs($sformatf("R1-vec%0d", i), exp_stb, 1'b0);
      end

      // strobe drops after one cycle once traffic stops
      drive(1'b1, 1'b0, 1'b0, 32'd0, 32'd0);
      @(negedge clk);
      check_outputs("R6 single pulse", 3'b000, 1'b0);

      // halt slot, data ignored
      drive(1'b1, 1'b1, 1'b1, BASE + 32'd12, 32'hFFFF_FFFF);
      @(negedge clk);
      check_outputs("R5 halt write", 3'b000, 1'b1);

      // channel still works while done is set
      drive(1'b1, 1'b1, 1'b1, BASE + 32'd0, 32'h0000_0021);
      @(negedge clk);
      m_scr = 8'h21;
      check_outputs("R7 done with screen write", 3'b100, 1'b1);

      drive(1'b0, 1'b0, 1'b0, 32'd0, 32'd0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check_outputs("R7 done sticky", 3'b000, 1'b1);
      end

      // reset coincides with an integer write
      rst_n = 1'b0;
      drive(1'b1, 1'b1, 1'b1, BASE + 32'd8, 32'h1111_2222);
      @(negedge clk);
      m_scr = '0; m_txt = '0; m_int = '0;
      check_outputs("R9 reset beats write", 3'b000, 1'b0);
      rst_n = 1'b1;
      drive(1'b0, 1'b0, 1'b0, 32'd0, 32'd0);
      @(negedge clk);
      check_outputs("R9 after reset", 3'b000, 1'b0);

      // halt with zero data also sets the flag
      drive(1'b1, 1'b1, 1'b1, BASE + 32'd12, 32'd0);
      @(negedge clk);
      check_outputs("R5 halt zero data", 3'b000, 1'b1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule